// File: doc/BRIEF.md
# Dual-Channel Maskable Interrupt Combiner

This block merges the interrupt requests of two disk channels into a single level-sensitive interrupt line. Each channel presents a request level. The block samples that level into a pending flag inside a shared mode byte. Beside each pending flag sits a block flag that software sets to silence that channel. The interrupt line is high whenever at least one channel has its pending flag set and its block flag clear.

Software reaches the block through a small byte-wide access port. Each channel has a four-byte register window. The shared mode byte sits at offset 1 of either window. Offset 3 holds a timing byte that belongs to the channel whose window is addressed. The timing bytes are plain storage, and nothing inside this block uses them.

In the mode byte, software can change only the block flags. A write there leaves the pending flags and the spare bits untouched. Read data comes back one cycle after the request, marked by a one-cycle valid strobe.

Top module: `dual_irq_combiner`

## Requirements
- R1: After reset, `irq_o` and `rd_valid` are low, the mode byte reads 0x00 and both timing bytes read 0x00.
- R2: In the mode byte, bit 2 is the channel 0 pending flag and bit 3 is the channel 1 pending flag. Each flag takes the value of its channel's request level at every clock edge, so it is set while the request is high and cleared once the request is low.
- R3: A write to offset 1 (from either window) loads write-data bits 5 and 4 into the block flags for channel 1 and channel 0. All other mode-byte bits are unaffected, so the pending flags cannot be written and bits 7:6 and 1:0 always read 0.
- R4: `irq_o` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode byte. It is registered and changes at the same clock edge that samples a new request level.
- R5: Offset 1 returns the same shared mode byte whichever channel window (`acc_chan` 0 or 1) is addressed.
- R6: Offset 3 reads and writes a timing byte private to the addressed channel. A write through one window leaves the other channel's timing byte unchanged.
- R7: Offsets 0 and 2 are outside this block. Reads there return 0xFF, and writes there change neither the mode byte nor the timing bytes.
- R8: A read request (`acc_en`=1, `acc_wr`=0) at one clock edge makes `rd_valid` high for exactly the following cycle, with `rd_data` holding the byte. Every other cycle has `rd_valid` low.
- R9: A block-flag write takes effect on `irq_o` at the same clock edge that loads the flag, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | 2 | Per-channel interrupt request levels |
| acc_en | input | 1 | Access request for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_chan | input | 1 | Channel window being addressed |
| acc_off | input | 2 | Byte offset inside the window |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid strobe, one cycle |
| rd_data | output | 8 | Read data |
| irq_o | output | 1 | Combined level interrupt |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This holds for a request-level change and for a block-flag write, both seen on `irq_o`, and for a read, seen on `rd_valid` and `rd_data`. The bench drives each stimulus on a falling edge and queues the expected line level and read result in a scoreboard. A monitor then checks them shortly after the next rising edge, one queued item per edge. This means a design that answers a cycle early or late is flagged on the spot.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFF_W    = 2;
  localparam logic [OFF_W-1:0] OFF_MODE = 2'd1;
  localparam logic [OFF_W-1:0] OFF_TIME = 2'd3;
  localparam int PEND_LSB = 2;
  localparam int MASK_LSB = 4;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/irqc_pend_sampler.sv
module irqc_pend_sampler #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] pend_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[c] <= 1'b0;
      else        pend_q[c] <= req_i[c];
    end
  end
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] mask_nxt,
  output logic [NCH-1:0] mask_q
);
  always_comb mask_nxt = wr_i ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irqc_timing_bank.sv
module irqc_timing_bank #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] tbyte [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbyte[c] <= '0;
      else if (wr_i && (sel_i == CW'(c)))
        tbyte[c] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (sel_i == CW'(c)) rdata_o = tbyte[c];
  end
endmodule

// File: rtl/irqc_line_combiner.sv
module irqc_line_combiner #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend_nxt,
  input  logic [NCH-1:0] mask_nxt,
  output logic           irq_q
);
  logic [NCH-1:0] live;
  always_comb live = pend_nxt & ~mask_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
endmodule

// File: rtl/dual_irq_combiner.sv
module dual_irq_combiner
  import irqc_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_req,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [CW-1:0]     acc_chan,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_o
);
  logic              mode_wr, time_wr, rd_req;
  logic [NCH-1:0]    pend_q, mask_q, mask_nxt;
  logic [BYTE_W-1:0] time_rd, mode_byte, rd_mux;

  always_comb begin
    rd_req  = acc_en && !acc_wr;
    mode_wr = acc_en && acc_wr && (acc_off == OFF_MODE);
    time_wr = acc_en && acc_wr && (acc_off == OFF_TIME);
  end

  irqc_pend_sampler #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(chan_req), .pend_q(pend_q));

  irqc_mask_reg #(.NCH(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mode_wr),
    .wdata_i(acc_wdata[MASK_LSB +: NCH]),
    .mask_nxt(mask_nxt), .mask_q(mask_q));

  irqc_timing_bank #(.NCH(NCH), .DW(BYTE_W)) u_time (
    .clk(clk), .rst_n(rst_n), .wr_i(time_wr), .sel_i(acc_chan),
    .wdata_i(acc_wdata), .rdata_o(time_rd));

  irqc_line_combiner #(.NCH(NCH)) u_line (
    .clk(clk), .rst_n(rst_n), .pend_nxt(chan_req),
    .mask_nxt(mask_nxt), .irq_q(irq_o));

  // Shared mode byte: pending flags and block flags, spare bits read 0
  always_comb begin
    mode_byte = '0;
    mode_byte[PEND_LSB +: NCH] = pend_q;
    mode_byte[MASK_LSB +: NCH] = mask_q;
  end

  always_comb begin
    unique case (acc_off)
      OFF_MODE: rd_mux = mode_byte;
      OFF_TIME: rd_mux = time_rd;
      default:  rd_mux = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dual_irq_combiner_chk.sv
module dual_irq_combiner_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] mask_q,
  input logic           mode_wr,
  input logic           time_wr,
  input logic           acc_en,
  input logic           acc_wr,
  input logic           rd_valid,
  input logic           irq_o
);
  AST_PEND_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q == $past(chan_req))); // R2

  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mask_q)); // R3

  AST_LINE_FROM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(pend_q & ~mask_q)); // R4

  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rd_valid); // R8

  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rd_valid); // R8

  AST_MASK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && time_wr)); // R7
endmodule

bind dual_irq_combiner dual_irq_combiner_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .pend_q(pend_q),
  .mask_q(mask_q), .mode_wr(mode_wr), .time_wr(time_wr), .acc_en(acc_en),
  .acc_wr(acc_wr), .rd_valid(rd_valid), .irq_o(irq_o));

// File: tb/dual_irq_combiner_bench.sv
`timescale 1ns/1ps
module dual_irq_combiner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_req = '0;
  logic       acc_en = 1'b0, acc_wr = 1'b0;
  logic [0:0] acc_chan = '0;
  logic [1:0] acc_off = '0;
  logic [7:0] acc_wdata = '0;
  logic       rd_valid, irq_o;
  logic [7:0] rd_data;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_irq_combiner u_dual_irq_combiner (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .acc_en(acc_en),
    .acc_wr(acc_wr), .acc_chan(acc_chan), .acc_off(acc_off),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_o(irq_o));

  // Reference model state
  logic [1:0] m_pend = '0, m_mask = '0;
  logic [7:0] m_tim [2] = '{8'h00, 8'h00};

  // Scoreboard queues
  bit         q_irq [$];
  bit         q_rv  [$];
  logic [7:0] q_rd  [$];
  string      q_tag [$];

  function automatic logic [7:0] mode_of(logic [1:0] p, logic [1:0] m);
    return {2'b00, m, p, 2'b00};
  endfunction

  task automatic step(input logic [1:0] req, input bit en, input bit wr,
                      input bit ch, input logic [1:0] off,
                      input logic [7:0] wd, input string tag);
    logic [7:0] exp_rd;
    @(negedge clk);
    chan_req = req; acc_en = en; acc_wr = wr; acc_chan = ch;
    acc_off = off; acc_wdata = wd;
    exp_rd = 8'hFF;
    if (off == 2'd1)      exp_rd = mode_of(m_pend, m_mask);
    else if (off == 2'd3) exp_rd = m_tim[ch];
    if (en && wr && off == 2'd1) m_mask = wd[5:4];
    if (en && wr && off == 2'd3) m_tim[ch] = wd;
    m_pend = req;
    q_irq.push_back(|(m_pend & ~m_mask));
    q_rv.push_back(en && !wr);
    q_rd.push_back(exp_rd);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input logic [1:0] req, input string tag);
    step(req, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Monitor: one queued item per rising edge, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (q_irq.size() > 0) begin
      automatic bit         e_irq = q_irq.pop_front();
      automatic bit         e_rv  = q_rv.pop_front();
      automatic logic [7:0] e_rd  = q_rd.pop_front();
      automatic string      t     = q_tag.pop_front();
      n_vec++;
      if (irq_o !== e_irq) begin
        n_bad++;
        $display("FAIL %s irq_o actual %0b expected %0b", t, irq_o, e_irq);
      end
      if (rd_valid !== e_rv) begin
        n_bad++;
        $display("FAIL %s rd_valid actual %0b expected %0b", t, rd_valid, e_rv);
      end
      if (e_rv && rd_data !== e_rd) begin
        n_bad++;
        $display("FAIL %s rd_data actual %02h expected %02h", t, rd_data, e_rd);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    n_vec++;
    if (irq_o !== 1'b0 || rd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual %0b/%0b expected 0/0", irq_o, rd_valid);
    end
    rst_n = 1'b1;
    // R1: reset contents
    step(2'b00, 1, 0, 0, 2'd1, 8'h00, "R1 mode after reset");
    step(2'b00, 1, 0, 0, 2'd3, 8'h00, "R1 timing0 after reset");
    step(2'b00, 1, 0, 1, 2'd3, 8'h00, "R1 timing1 after reset");
    // R2/R4: channel 0 request raises line
    idle(2'b01, "R2 R4 req0 rises");
    step(2'b01, 1, 0, 0, 2'd1, 8'h00, "R2 mode shows bit2");
    // R9: blocking channel 0 drops line on the write edge
    step(2'b01, 1, 1, 0, 2'd1, 8'h10, "R9 block ch0");
    step(2'b01, 1, 0, 0, 2'd1, 8'h00, "R3 mode 0x14");
    // R5: channel 1 request, read through channel 1 window
    idle(2'b11, "R4 req1 unblocked");
    step(2'b11, 1, 0, 1, 2'd1, 8'h00, "R5 mode via ch1 window");
    // R3: full-byte write only takes bits 5:4
    step(2'b11, 1, 1, 1, 2'd1, 8'hEF, "R3 write 0xEF");
    step(2'b11, 1, 0, 0, 2'd1, 8'h00, "R3 mode 0x2C");
    step(2'b11, 1, 1, 0, 2'd1, 8'h30, "R4 both blocked");
    step(2'b00, 1, 1, 0, 2'd1, 8'h0C, "R3 pending not writable");
    step(2'b00, 1, 0, 1, 2'd1, 8'h00, "R3 mode 0x00");
    idle(2'b10, "R4 req1 alone");
    idle(2'b00, "R2 req1 falls");
    // R6: private timing bytes
    step(2'b00, 1, 1, 0, 2'd3, 8'hA5, "R6 write t0");
    step(2'b00, 1, 1, 1, 2'd3, 8'h3C, "R6 write t1");
    step(2'b00, 1, 0, 0, 2'd3, 8'h00, "R6 read t0");
    step(2'b00, 1, 0, 1, 2'd3, 8'h00, "R6 read t1");
    step(2'b00, 1, 1, 1, 2'd3, 8'h77, "R6 rewrite t1");
    step(2'b00, 1, 0, 0, 2'd3, 8'h00, "R6 t0 kept");
    // R7: foreign offsets
    step(2'b00, 1, 1, 0, 2'd0, 8'h30, "R7 write off0");
    step(2'b00, 1, 1, 1, 2'd2, 8'hFF, "R7 write off2");
    step(2'b00, 1, 0, 0, 2'd0, 8'h00, "R7 read off0");
    step(2'b00, 1, 0, 1, 2'd2, 8'h00, "R7 read off2");
    step(2'b01, 1, 0, 0, 2'd1, 8'h00, "R7 mask untouched");
    step(2'b01, 1, 0, 1, 2'd3, 8'h00, "R7 t1 untouched");
    // R8: back-to-back reads then idle
    for (int i = 0; i < 4; i++)
      step(2'b01, 1, 0, 1'(i), 2'(i), 8'h00, "R8 back-to-back");
    idle(2'b00, "R8 strobe ends");
    idle(2'b00, "R8 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule